// File: doc/BRIEF.md
# Host Parallel Register Port

This block is the parallel port through which a host processor configures a sampling converter and collects its results. The host drives an active-low chip select, write strobe and output enable, a 2-bit address and a 14-bit data word. The port decodes four locations. Location 0 is the read-only result port; a read there pops one word from the sample FIFO. Location 1 holds the gain code, location 2 holds the offset-correction value, and location 3 holds the control word.

The control word is split into named fields, and those fields drive the neighbouring blocks: power-down, reference select, output format, test mode, offset bypass, interrupt and overflow polarity, FIFO enable and FIFO threshold. The tri-state bus is modelled as a data-out word plus an output-enable flag, which the pad ring combines.

The host pins are treated as synchronous to `clk`. Each strobe is sampled once per cycle, and its edges are found by comparing it with the value sampled one cycle earlier.

Top module: `host_regif`

## Requirements
- R1: After synchronous reset, the following are all zero: every configuration output, `dout`, `dout_en` and `pop`. Reads of locations 1, 2 and 3 then return 0.
- R2: A write is performed at the clock edge where `wr_n` is sampled high after being sampled low in the previous cycle, with `cs_n` low. At that edge, `din` is stored into the location selected by `addr`. The gain location keeps only `din[2:0]`, output as `gain_code`. The offset location keeps only `din[7:0]`, an 8-bit two's-complement value, output as `offset_val`.
- R3: A write strobe while `cs_n` is high changes no register.
- R4: A write to location 0 changes no register.
- R5: Reads return the stored value with all unused upper bits zero. Location 1 returns `{11'b0, gain}`, location 2 returns `{6'b0, offset}`, and location 3 returns the full 14-bit control word.
- R6: The control word decodes as follows:
  - bit 13: `pwr_down`
  - bit 12: `ext_ref`
  - bit 11: `fmt_twos`
  - bits 10:8: `test_mode`
  - bit 7: `ofs_bypass`
  - bit 6: `irq_pol`
  - bit 5: `ovf_pol`
  - bit 4: `fifo_en`
  - bits 3:0: `thresh`
- R7: `test_active` is 0 for the test-mode codes 000 and 100, which both mean normal operation. It is 1 for every other code.
- R8: `pop` is a one-cycle pulse. It is issued in the cycle after the edge that first samples `oe_n` low (after a high sample) with `cs_n` low and `addr` = 0. Holding `oe_n` low gives no further pulse. Reads of other locations give none, and neither does `oe_n` falling while `cs_n` is high.
- R9: A read of location 0 returns `result_in` on `dout`.
- R10: `dout_en` is 1 in the cycle after an edge that samples both `oe_n` and `cs_n` low, and 0 otherwise. While `dout_en` is 0, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; the write happens on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 2 | Location select |
| din | input | 14 | Write data from host |
| result_in | input | 14 | Word at the head of the sample FIFO |
| dout | output | 14 | Read data to the bus drivers |
| dout_en | output | 1 | Bus driver enable |
| pop | output | 1 | One-cycle FIFO pop request |
| gain_code | output | 3 | Gain step code, 1 dB per step |
| offset_val | output | 8 | Signed offset correction |
| pwr_down | output | 1 | Power-down request |
| ext_ref | output | 1 | External reference select |
| fmt_twos | output | 1 | Two's-complement output format |
| test_mode | output | 3 | Raw test-mode code |
| test_active | output | 1 | A real test mode is selected |
| ofs_bypass | output | 1 | Offset correction disabled |
| irq_pol | output | 1 | Interrupt polarity, 1 = high active |
| ovf_pol | output | 1 | Overflow polarity, 1 = high active |
| fifo_en | output | 1 | FIFO enable |
| thresh | output | 4 | FIFO threshold code |

## Verification
A register write takes effect at the clock edge that samples `wr_n` high after a low sample. The bench therefore checks the configuration outputs at the falling clock edge that follows the strobe's release. A read result, `dout_en` and `pop` all appear one edge after `oe_n` is first sampled low, so the bench samples them at the next falling edge. It samples again one cycle later to confirm that `pop` has already dropped while `oe_n` is still held low. Writes that must be ignored are confirmed by reading every register back afterwards.

// File: rtl/host_regif_pkg.sv
package host_regif_pkg;

  typedef enum logic [1:0] {
    LOC_RESULT = 2'd0,
    LOC_GAIN   = 2'd1,
    LOC_OFFSET = 2'd2,
    LOC_CTRL   = 2'd3
  } loc_e;

  // first member is the most significant bit (bit 13)
  typedef struct packed {
    logic       pwr_down;
    logic       ext_ref;
    logic       fmt_twos;
    logic [2:0] test_mode;
    logic       ofs_bypass;
    logic       irq_pol;
    logic       ovf_pol;
    logic       fifo_en;
    logic [3:0] thresh;
  } ctrl_t;

endpackage

// File: rtl/regif_strobe.sv
module regif_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  input  logic oe_n,
  output logic wr_evt,
  output logic rd_start,
  output logic rd_active
);
  logic wr_q;
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      oe_q <= oe_n;
    end
  end

  always_comb begin
    wr_evt    = !wr_q && wr_n && !cs_n;
    rd_active = !oe_n && !cs_n;
    rd_start  = oe_q && rd_active;
  end

endmodule

// File: rtl/regif_bank.sv
module regif_bank
  import host_regif_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_q,
  output logic [OFS_W-1:0]  ofs_q,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] gain_rb,
  output logic [DATA_W-1:0] ofs_rb,
  output logic [DATA_W-1:0] ctrl_rb
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      ofs_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_evt) begin
      case (loc_e'(wr_addr))
        LOC_GAIN:   gain_q <= wr_data[GAIN_W-1:0];
        LOC_OFFSET: ofs_q  <= wr_data[OFS_W-1:0];
        LOC_CTRL:   ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:    ;
      endcase
    end
  end

  // zero-extend each register onto the full bus width
  always_comb begin
    gain_rb = '0;
    ofs_rb  = '0;
    ctrl_rb = '0;
    gain_rb[GAIN_W-1:0] = gain_q;
    ofs_rb[OFS_W-1:0]   = ofs_q;
    ctrl_rb[CTRL_W-1:0] = ctrl_q;
  end

  // R4: a write aimed at the result location leaves every register untouched
  a_r4_result_wr_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && wr_addr == 2'd0) |=> ($stable(gain_q) && $stable(ofs_q) && $stable(ctrl_q)));

endmodule

// File: rtl/regif_read.sv
module regif_read
  import host_regif_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              rd_active,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] result_in,
  input  logic [DATA_W-1:0] gain_rb,
  input  logic [DATA_W-1:0] ofs_rb,
  input  logic [DATA_W-1:0] ctrl_rb,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pop
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (loc_e'(addr))
      LOC_RESULT: sel = result_in;
      LOC_GAIN:   sel = gain_rb;
      LOC_OFFSET: sel = ofs_rb;
      default:    sel = ctrl_rb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
      pop     <= 1'b0;
    end else begin
      dout_en <= rd_active;
      dout    <= rd_active ? sel : '0;
      pop     <= rd_start && (addr == 2'd0);
    end
  end

  // R8: a pop never lasts longer than one cycle
  a_r8_pop_single: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);

  // R8: a pop only happens during an enabled read
  a_r8_pop_in_read: assert property (@(posedge clk) disable iff (rst)
    pop |-> dout_en);

  // R10: the bus word is quiet whenever the drivers are off
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

endmodule

// File: rtl/host_regif.sv
module host_regif
  import host_regif_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8,
  parameter int TM_W   = 3,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] result_in,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pop,
  output logic [GAIN_W-1:0] gain_code,
  output logic [OFS_W-1:0]  offset_val,
  output logic              pwr_down,
  output logic              ext_ref,
  output logic              fmt_twos,
  output logic [TM_W-1:0]   test_mode,
  output logic              test_active,
  output logic              ofs_bypass,
  output logic              irq_pol,
  output logic              ovf_pol,
  output logic              fifo_en,
  output logic [THR_W-1:0]  thresh
);
  logic              wr_evt, rd_start, rd_active;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] gain_rb, ofs_rb, ctrl_rb;

  regif_strobe u_strobe (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .wr_evt    (wr_evt),
    .rd_start  (rd_start),
    .rd_active (rd_active)
  );

  regif_bank #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_evt  (wr_evt),
    .wr_addr (addr),
    .wr_data (din),
    .gain_q  (gain_code),
    .ofs_q   (offset_val),
    .ctrl_q  (ctrl_q),
    .gain_rb (gain_rb),
    .ofs_rb  (ofs_rb),
    .ctrl_rb (ctrl_rb)
  );

  regif_read #(.DATA_W(DATA_W)) u_read (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_active (rd_active),
    .addr      (addr),
    .result_in (result_in),
    .gain_rb   (gain_rb),
    .ofs_rb    (ofs_rb),
    .ctrl_rb   (ctrl_rb),
    .dout      (dout),
    .dout_en   (dout_en),
    .pop       (pop)
  );

  always_comb begin
    pwr_down    = ctrl_q.pwr_down;
    ext_ref     = ctrl_q.ext_ref;
    fmt_twos    = ctrl_q.fmt_twos;
    test_mode   = ctrl_q.test_mode;
    ofs_bypass  = ctrl_q.ofs_bypass;
    irq_pol     = ctrl_q.irq_pol;
    ovf_pol     = ctrl_q.ovf_pol;
    fifo_en     = ctrl_q.fifo_en;
    thresh      = ctrl_q.thresh;
    // codes x00 select normal operation
    test_active = |ctrl_q.test_mode[TM_W-2:0];
  end

  // R3: with chip select high, a write strobe leaves the gain code alone
  a_r3_cs_gates_write: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(gain_code));

endmodule

// File: tb/tb_host_regif.sv
module tb_host_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [13:0] din = '0, result_in = '0;
  logic [13:0] dout;
  logic        dout_en, pop;
  logic [2:0]  gain_code;
  logic [7:0]  offset_val;
  logic        pwr_down, ext_ref, fmt_twos, test_active, ofs_bypass, irq_pol, ovf_pol, fifo_en;
  logic [2:0]  test_mode;
  logic [3:0]  thresh;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  host_regif dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .addr(addr),
    .din(din), .result_in(result_in), .dout(dout), .dout_en(dout_en), .pop(pop),
    .gain_code(gain_code), .offset_val(offset_val), .pwr_down(pwr_down),
    .ext_ref(ext_ref), .fmt_twos(fmt_twos), .test_mode(test_mode),
    .test_active(test_active), .ofs_bypass(ofs_bypass), .irq_pol(irq_pol),
    .ovf_pol(ovf_pol), .fifo_en(fifo_en), .thresh(thresh)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [13:0] d, input logic cs_val);
    @(negedge clk);
    cs_n = cs_val; addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic host_read(input logic [1:0] a, input logic cs_val,
                           output logic [13:0] d, output logic en,
                           output logic p_first, output logic p_second,
                           output logic en_after);
    @(negedge clk);
    cs_n = cs_val; addr = a; oe_n = 1'b0;
    @(negedge clk);
    d = dout; en = dout_en; p_first = pop;
    @(negedge clk);
    p_second = pop;
    oe_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    en_after = dout_en;
  endtask

  task automatic read_value(input logic [1:0] a, output logic [13:0] d);
    logic en, p1, p2, ea;
    host_read(a, 1'b0, d, en, p1, p2, ea);
  endtask

  task automatic t_reset();
    logic [13:0] d;
    check("R1 dout_en", dout_en, 0);
    check("R1 pop", pop, 0);
    check("R1 dout", dout, 0);
    check("R1 gain_code", gain_code, 0);
    check("R1 offset_val", offset_val, 0);
    check("R1 ctrl fields", {pwr_down, ext_ref, fmt_twos, test_mode, ofs_bypass,
                             irq_pol, ovf_pol, fifo_en, thresh, test_active}, 0);
    read_value(2'd1, d); check("R1 gain readback", d, 0);
    read_value(2'd2, d); check("R1 offset readback", d, 0);
    read_value(2'd3, d); check("R1 ctrl readback", d, 0);
  endtask

  task automatic t_gain_offset();
    logic [13:0] d;
    host_write(2'd1, 14'h3FFD, 1'b0);
    check("R2 gain keeps low 3 bits", gain_code, 5);
    read_value(2'd1, d); check("R5 gain readback upper zero", d, 14'h0005);
    host_write(2'd2, 14'h2A80, 1'b0);
    check("R2 offset low byte (-128)", offset_val, 8'h80);
    read_value(2'd2, d); check("R5 offset readback upper zero", d, 14'h0080);
  endtask

  task automatic t_ctrl();
    logic [13:0] d;
    host_write(2'd3, 14'h2A5B, 1'b0);
    check("R6 pwr_down", pwr_down, 1);
    check("R6 ext_ref", ext_ref, 0);
    check("R6 fmt_twos", fmt_twos, 1);
    check("R6 test_mode", test_mode, 3'b010);
    check("R6 ofs_bypass", ofs_bypass, 0);
    check("R6 irq_pol", irq_pol, 1);
    check("R6 ovf_pol", ovf_pol, 0);
    check("R6 fifo_en", fifo_en, 1);
    check("R6 thresh", thresh, 4'hB);
    check("R7 code 010 active", test_active, 1);
    read_value(2'd3, d); check("R5 ctrl readback", d, 14'h2A5B);
  endtask

  task automatic t_test_codes();
    host_write(2'd3, 14'h0400, 1'b0);
    check("R7 code 100 mode", test_mode, 3'b100);
    check("R7 code 100 normal", test_active, 0);
    host_write(2'd3, 14'h0500, 1'b0);
    check("R7 code 101 active", test_active, 1);
    host_write(2'd3, 14'h0000, 1'b0);
    check("R7 code 000 normal", test_active, 0);
    host_write(2'd3, 14'h10F0, 1'b0);
    check("R6 ext_ref/flags", {ext_ref, ofs_bypass, irq_pol, ovf_pol, fifo_en, thresh}, 10'b1_1111_0000);
  endtask

  task automatic t_ignored_writes();
    logic [13:0] d;
    host_write(2'd1, 14'h0002, 1'b0);
    host_write(2'd1, 14'h0007, 1'b1);
    check("R3 cs high gain unchanged", gain_code, 2);
    read_value(2'd1, d); check("R3 gain readback", d, 2);
    host_write(2'd0, 14'h3FFF, 1'b0);
    read_value(2'd1, d); check("R4 gain after addr0 write", d, 2);
    read_value(2'd2, d); check("R4 offset after addr0 write", d, 14'h0080);
    read_value(2'd3, d); check("R4 ctrl after addr0 write", d, 14'h10F0);
  endtask

  task automatic t_result_pop();
    logic [13:0] d;
    logic en, p1, p2, ea;
    result_in = 14'h1234;
    host_read(2'd0, 1'b0, d, en, p1, p2, ea);
    check("R9 result data", d, 14'h1234);
    check("R10 enable during read", en, 1);
    check("R8 pop pulse", p1, 1);
    check("R8 no second pop while held", p2, 0);
    check("R10 enable off after release", ea, 0);
    check("R10 dout zero after release", dout, 0);
    result_in = 14'h2DCB;
    host_read(2'd0, 1'b0, d, en, p1, p2, ea);
    check("R9 second result", d, 14'h2DCB);
    check("R8 pop on second read", p1, 1);
    host_read(2'd1, 1'b0, d, en, p1, p2, ea);
    check("R8 no pop for gain read", p1 | p2, 0);
    host_read(2'd0, 1'b1, d, en, p1, p2, ea);
    check("R8 no pop with cs high", p1 | p2, 0);
    check("R10 no enable with cs high", en, 0);
    check("R10 dout zero with cs high", d, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gain_offset();
    t_ctrl();
    t_test_codes();
    t_ignored_writes();
    t_result_pop();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule